// File: doc/BRIEF.md
# Ethernet Domain Reset Controller

This block produces the reset lines for the internal domains of an Ethernet controller. It takes one chip-level hard reset and combines it with reset bits that software writes through a small register port. One register holds six level-type reset bits for the MAC: transmit, receive, the pause-frame control sublayer, the transmit backoff random generator and a MAC-wide reset. These bits stay as written. A second register holds two datapath reset bits. Each of these fires a fixed-length pulse on the transmit or receive datapath reset and then clears itself.

Each self-clearing pulse also gives a one-cycle strobe that tells the DMA side to abandon its outstanding bus transfer. A second one-cycle strobe clears the matching status flag. Each domain reset output is the OR of the internal hard reset and every software bit that covers that domain. The hard reset asserts asynchronously. Its release passes through a synchroniser chain before it reaches the domains.

Top module: `eth_rst_ctrl`

## Requirements
- R1: While `hard_rst_n` is low, every domain reset output is 1 without waiting for a clock edge, both strobes are 0, the configuration register (address 0) reads 0x20 and the command register (address 1) reads 0.
- R2: After `hard_rst_n` rises, the hard-reset contribution to the domain resets ends after exactly SYNC_STAGES (default 2) rising clock edges. With defaults, `rst_tx_dp` is still 1 after the first edge and 0 after the second.
- R3: Configuration bit 5 (MAC-wide) is 1 out of hard reset. While it is set, `rst_mac_core`, `rst_mac_tx`, `rst_mac_rx`, `rst_ctl_sub` and `rst_rng` are all 1. Clearing it releases `rst_mac_core` one edge after the write.
- R4: Configuration bit 4 asserts `rst_rng` only.
- R5: Configuration bit 1 asserts `rst_ctl_sub` and `rst_mac_tx`. Configuration bit 3 asserts `rst_ctl_sub` and `rst_mac_rx`.
- R6: Configuration bit 0 asserts only `rst_mac_tx`. Configuration bit 2 asserts only `rst_mac_rx`.
- R7: Configuration bits hold their written value and read back unchanged until software writes address 0 again. Writes to other addresses do not change them, and they never drive the datapath resets.
- R8: Writing 1 to command bit 0 drives `rst_tx_dp` to 1 for exactly two cycles, starting at the write edge. Command bit 0 reads 1 during the pulse and 0 afterwards.
- R9: The first cycle of a transmit pulse raises `tx_abort` and `tx_stat_clr` for one cycle only.
- R10: Writing 1 to command bit 1 gives the same two-cycle `rst_rx_dp` pulse, readback and one-cycle `rx_abort`/`rx_stat_clr` strobes. Both bits in one write fire both sides together.
- R11: Writing 0 to a command bit has no effect. Writing 1 while a pulse is running restarts its two-cycle window and its strobe.
- R12: Reads of addresses other than 0 and 1 return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst_n | input | 1 | Chip hard reset, active low, asynchronous |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW (2) | Register address for reads and writes |
| wdata | input | DW (8) | Write data |
| rdata | output | DW (8) | Read data for `addr`, combinational |
| rst_mac_tx | output | 1 | MAC transmit function reset |
| rst_mac_rx | output | 1 | MAC receive function reset |
| rst_ctl_sub | output | 1 | Pause-frame control sublayer reset |
| rst_rng | output | 1 | Transmit backoff random generator reset |
| rst_mac_core | output | 1 | Reset of all MAC modules except its register bank |
| rst_tx_dp | output | 1 | Transmit datapath reset, including produce index |
| rst_rx_dp | output | 1 | Receive datapath reset, including consume index |
| tx_abort | output | 1 | One-cycle abort of outstanding transmit bus transfer |
| rx_abort | output | 1 | One-cycle abort of outstanding receive bus transfer |
| tx_stat_clr | output | 1 | One-cycle clear of transmit status flag |
| rx_stat_clr | output | 1 | One-cycle clear of receive status flag |

## Verification
A wrong configuration bit appears on at least one domain reset output in the cycle after the write edge. It also appears in the register readback at once. The sweep over all 64 configuration values therefore exposes any wrong or missing coverage term immediately. A wrong pulse counter shows as a datapath reset that drops one cycle early or stays one cycle too long, and the cycle-by-cycle samples catch this within three cycles of the write. A faulty synchroniser shifts the release of `rst_tx_dp` by one edge after hard reset is removed.

// File: rtl/eth_rst_pkg.sv
package eth_rst_pkg;
   // configuration register bit positions (software-visible layout)
   localparam int CFG_TX    = 0;
   localparam int CFG_CTX   = 1;
   localparam int CFG_RX    = 2;
   localparam int CFG_CRX   = 3;
   localparam int CFG_RNG   = 4;
   localparam int CFG_ALL   = 5;
   localparam int CFG_BITS  = 6;
   localparam logic [CFG_BITS-1:0] CFG_DEFAULT = 6'b10_0000;

   // command register bit positions
   localparam int CMD_TXDP  = 0;
   localparam int CMD_RXDP  = 1;
   localparam int CMD_BITS  = 2;

   typedef struct packed {
      logic mac_tx;
      logic mac_rx;
      logic ctl_sub;
      logic rng;
      logic mac_core;
   } mac_rst_t;
endpackage

// File: rtl/eth_rst_sync.sv
module eth_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic rst_o
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) chain <= 1'b0;
            else         chain <= 1'b1;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) chain <= '0;
            else         chain <= {chain[STAGES-2:0], 1'b1};
         end
      end
   endgenerate

   assign rst_o = ~chain[STAGES-1];
endmodule

// File: rtl/eth_rst_selfclr.sv
module eth_rst_selfclr #(
   parameter int PULSE_CYC = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic trig,
   output logic pulse,
   output logic strobe
);
   localparam int CW = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
   localparam logic [CW-1:0] CNT_LOAD = CW'(PULSE_CYC - 1);

   logic [CW-1:0] remain;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         pulse  <= 1'b0;
         strobe <= 1'b0;
         remain <= '0;
      end else if (trig) begin
         pulse  <= 1'b1;
         strobe <= 1'b1;
         remain <= CNT_LOAD;
      end else begin
         strobe <= 1'b0;
         if (pulse) begin
            if (remain == '0) pulse  <= 1'b0;
            else              remain <= remain - 1'b1;
         end
      end
   end
endmodule

// File: rtl/eth_rst_map.sv
module eth_rst_map
   import eth_rst_pkg::*;
(
   input  logic                hard,
   input  logic [CFG_BITS-1:0] cfg,
   output mac_rst_t            dom
);
   logic all_mac;

   always_comb begin
      all_mac      = hard | cfg[CFG_ALL];
      dom.mac_core = all_mac;
      dom.mac_tx   = all_mac | cfg[CFG_TX] | cfg[CFG_CTX];
      dom.mac_rx   = all_mac | cfg[CFG_RX] | cfg[CFG_CRX];
      dom.ctl_sub  = all_mac | cfg[CFG_CTX] | cfg[CFG_CRX];
      dom.rng      = all_mac | cfg[CFG_RNG];
   end
endmodule

// File: rtl/eth_rst_ctrl.sv
module eth_rst_ctrl
   import eth_rst_pkg::*;
#(
   parameter int AW          = 2,
   parameter int DW          = 8,
   parameter int CFG_ADDR    = 0,
   parameter int CMD_ADDR    = 1,
   parameter int SYNC_STAGES = 2,
   parameter int PULSE_CYC   = 2
) (
   input  logic          clk,
   input  logic          hard_rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   output logic          rst_mac_tx,
   output logic          rst_mac_rx,
   output logic          rst_ctl_sub,
   output logic          rst_rng,
   output logic          rst_mac_core,
   output logic          rst_tx_dp,
   output logic          rst_rx_dp,
   output logic          tx_abort,
   output logic          rx_abort,
   output logic          tx_stat_clr,
   output logic          rx_stat_clr
);
   localparam logic [AW-1:0] A_CFG = AW'(CFG_ADDR);
   localparam logic [AW-1:0] A_CMD = AW'(CMD_ADDR);

   generate
      if (DW < CFG_BITS)           begin : g_bad_dw   $error("DW too narrow for configuration register"); end
      if (CFG_ADDR == CMD_ADDR)    begin : g_bad_addr $error("register addresses overlap"); end
      if (SYNC_STAGES < 1)         begin : g_bad_sync $error("SYNC_STAGES must be at least 1"); end
      if (PULSE_CYC < 1)           begin : g_bad_pls  $error("PULSE_CYC must be at least 1"); end
      if ((1 << AW) <= CFG_ADDR || (1 << AW) <= CMD_ADDR) begin : g_bad_aw
         $error("address does not fit AW");
      end
      if (DW > CFG_BITS) begin : g_wide
         logic unused_wdata_hi;
         assign unused_wdata_hi = ^wdata[DW-1:CFG_BITS];
      end
   endgenerate

   // hard reset: async assert, synchronised release
   logic rst_int;
   eth_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .arst_n (hard_rst_n),
      .rst_o  (rst_int)
   );

   // sticky MAC-level reset bits
   logic [CFG_BITS-1:0] cfg_q;
   logic                cfg_we, cmd_we;

   assign cfg_we = wr_en && (addr == A_CFG);
   assign cmd_we = wr_en && (addr == A_CMD);

   always_ff @(posedge clk or posedge rst_int) begin
      if (rst_int)     cfg_q <= CFG_DEFAULT;
      else if (cfg_we) cfg_q <= wdata[CFG_BITS-1:0];
   end

   // self-clearing datapath resets, one channel per command bit
   logic [CMD_BITS-1:0] dp_pulse, dp_strobe;

   generate
      for (genvar g = 0; g < CMD_BITS; g++) begin : g_dp
         eth_rst_selfclr #(.PULSE_CYC(PULSE_CYC)) u_pulse (
            .clk    (clk),
            .rst    (rst_int),
            .trig   (cmd_we && wdata[g]),
            .pulse  (dp_pulse[g]),
            .strobe (dp_strobe[g])
         );
      end
   endgenerate

   // domain reset mapping
   mac_rst_t dom;
   eth_rst_map u_map (
      .hard (rst_int),
      .cfg  (cfg_q),
      .dom  (dom)
   );

   assign rst_mac_tx   = dom.mac_tx;
   assign rst_mac_rx   = dom.mac_rx;
   assign rst_ctl_sub  = dom.ctl_sub;
   assign rst_rng      = dom.rng;
   assign rst_mac_core = dom.mac_core;
   assign rst_tx_dp    = rst_int | dp_pulse[CMD_TXDP];
   assign rst_rx_dp    = rst_int | dp_pulse[CMD_RXDP];
   assign tx_abort     = dp_strobe[CMD_TXDP];
   assign rx_abort     = dp_strobe[CMD_RXDP];
   assign tx_stat_clr  = dp_strobe[CMD_TXDP];
   assign rx_stat_clr  = dp_strobe[CMD_RXDP];

   // register readback
   always_comb begin
      rdata = '0;
      if (addr == A_CFG)      rdata = DW'(cfg_q);
      else if (addr == A_CMD) rdata = DW'(dp_pulse);
   end
endmodule

// File: rtl/eth_rst_ctrl_chk.sv
module eth_rst_ctrl_chk
   import eth_rst_pkg::*;
#(
   parameter int AW       = 2,
   parameter int DW       = 8,
   parameter int CFG_ADDR = 0,
   parameter int CMD_ADDR = 1
) (
   input logic          clk,
   input logic          hard_rst_n,
   input logic          rst_int,
   input logic          wr_en,
   input logic [AW-1:0] addr,
   input logic [DW-1:0] wdata,
   input logic          rst_mac_tx,
   input logic          rst_mac_rx,
   input logic          rst_ctl_sub,
   input logic          rst_rng,
   input logic          rst_mac_core,
   input logic          rst_tx_dp,
   input logic          rst_rx_dp,
   input logic          tx_abort,
   input logic          rx_abort,
   input logic          tx_stat_clr,
   input logic          rx_stat_clr
);
   logic cfg_w, tx_go, rx_go;
   assign cfg_w = wr_en && (addr == AW'(CFG_ADDR));
   assign tx_go = wr_en && (addr == AW'(CMD_ADDR)) && wdata[CMD_TXDP];
   assign rx_go = wr_en && (addr == AW'(CMD_ADDR)) && wdata[CMD_RXDP];

   p_hard_all_r1: assert property (@(posedge clk)
      !hard_rst_n |-> (rst_mac_core && rst_tx_dp && rst_rx_dp && !tx_abort && !rx_abort));

   p_macall_covers_r3: assert property (@(posedge clk)
      rst_mac_core |-> (rst_mac_tx && rst_mac_rx && rst_ctl_sub && rst_rng));

   p_macall_clear_r3: assert property (@(posedge clk) disable iff (rst_int || !hard_rst_n)
      (cfg_w && !wdata[CFG_ALL]) |=> !rst_mac_core);

   p_sticky_r7: assert property (@(posedge clk) disable iff (rst_int || !hard_rst_n)
      !cfg_w |=> $stable({rst_mac_tx, rst_mac_rx, rst_ctl_sub, rst_rng, rst_mac_core}));

   p_tx_fire_r8: assert property (@(posedge clk) disable iff (rst_int || !hard_rst_n)
      tx_go |=> (rst_tx_dp && tx_abort && tx_stat_clr));

   p_tx_hold_r8: assert property (@(posedge clk) disable iff (rst_int || !hard_rst_n)
      tx_abort |=> rst_tx_dp);

   p_tx_once_r9: assert property (@(posedge clk) disable iff (rst_int || !hard_rst_n)
      (tx_abort && !tx_go) |=> !tx_abort);

   p_rx_fire_r10: assert property (@(posedge clk) disable iff (rst_int || !hard_rst_n)
      rx_go |=> (rst_rx_dp && rx_abort && rx_stat_clr));

   p_rx_once_r10: assert property (@(posedge clk) disable iff (rst_int || !hard_rst_n)
      (rx_abort && !rx_go) |=> !rx_abort);

   p_no_spurious_r11: assert property (@(posedge clk) disable iff (rst_int || !hard_rst_n)
      (!tx_go && !rst_tx_dp) |=> !rst_tx_dp);
endmodule

bind eth_rst_ctrl eth_rst_ctrl_chk #(
   .AW(AW), .DW(DW), .CFG_ADDR(CFG_ADDR), .CMD_ADDR(CMD_ADDR)
) u_chk (
   .clk(clk), .hard_rst_n(hard_rst_n), .rst_int(rst_int),
   .wr_en(wr_en), .addr(addr), .wdata(wdata),
   .rst_mac_tx(rst_mac_tx), .rst_mac_rx(rst_mac_rx), .rst_ctl_sub(rst_ctl_sub),
   .rst_rng(rst_rng), .rst_mac_core(rst_mac_core),
   .rst_tx_dp(rst_tx_dp), .rst_rx_dp(rst_rx_dp),
   .tx_abort(tx_abort), .rx_abort(rx_abort),
   .tx_stat_clr(tx_stat_clr), .rx_stat_clr(rx_stat_clr)
);

// File: tb/eth_rst_ctrl_test.sv
module eth_rst_ctrl_test;
   logic       clk = 1'b0;
   logic       hard_rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic rst_mac_tx, rst_mac_rx, rst_ctl_sub, rst_rng, rst_mac_core;
   logic rst_tx_dp, rst_rx_dp, tx_abort, rx_abort, tx_stat_clr, rx_stat_clr;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   eth_rst_ctrl uut (
      .clk(clk), .hard_rst_n(hard_rst_n), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata),
      .rst_mac_tx(rst_mac_tx), .rst_mac_rx(rst_mac_rx), .rst_ctl_sub(rst_ctl_sub),
      .rst_rng(rst_rng), .rst_mac_core(rst_mac_core),
      .rst_tx_dp(rst_tx_dp), .rst_rx_dp(rst_rx_dp),
      .tx_abort(tx_abort), .rx_abort(rx_abort),
      .tx_stat_clr(tx_stat_clr), .rx_stat_clr(rx_stat_clr)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
      end
   endtask

   // write captured at the next rising edge; returns on the falling edge after it
   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   function automatic logic [4:0] exp_dom(input logic [5:0] v);
      logic a;
      a = v[5];
      // {mac_tx, mac_rx, ctl_sub, rng, mac_core}
      return {a | v[0] | v[1], a | v[2] | v[3], a | v[1] | v[3], a | v[4], a};
   endfunction

   task automatic chk_dp(input string req, input logic tp, input logic ts,
                         input logic rp, input logic rs);
      logic [7:0] d;
      chk(req, {rst_tx_dp, tx_abort, tx_stat_clr}, {tp, ts, ts});
      chk(req, {rst_rx_dp, rx_abort, rx_stat_clr}, {rp, rs, rs});
      rd(2'd1, d);
      chk(req, d, {6'd0, rp, tp});
   endtask

   initial begin
      logic [7:0] d;
      // R1: in reset
      #12;
      chk("R1 domains", {rst_mac_tx, rst_mac_rx, rst_ctl_sub, rst_rng, rst_mac_core,
                         rst_tx_dp, rst_rx_dp}, 7'h7f);
      chk("R1 strobes", {tx_abort, rx_abort, tx_stat_clr, rx_stat_clr}, 4'h0);
      rd(2'd0, d); chk("R1 cfg read", d, 8'h20);
      rd(2'd1, d); chk("R1 cmd read", d, 8'h00);

      // R2: release through two-stage sync
      @(negedge clk); hard_rst_n = 1'b1;
      @(negedge clk); chk("R2 edge1", rst_tx_dp, 1'b1);
      @(negedge clk); chk("R2 edge2", {rst_tx_dp, rst_rx_dp}, 2'b00);
      chk("R3 default", {rst_mac_tx, rst_mac_rx, rst_ctl_sub, rst_rng, rst_mac_core}, 5'h1f);

      // R3-R7: sweep all configuration values
      for (int v = 0; v < 64; v++) begin
         wr(2'd0, 8'(v));
         chk("R3 R4 R5 R6 map", {rst_mac_tx, rst_mac_rx, rst_ctl_sub, rst_rng, rst_mac_core},
             exp_dom(6'(v)));
         rd(2'd0, d); chk("R7 readback", d, 8'(v));
         chk("R7 no dp", {rst_tx_dp, rst_rx_dp}, 2'b00);
      end

      // R7 + R12: other addresses leave config alone
      wr(2'd0, 8'h0a);
      wr(2'd2, 8'hff);
      chk("R12 unmapped write", {rst_tx_dp, rst_rx_dp, tx_abort, rx_abort}, 4'h0);
      rd(2'd0, d); chk("R7 cfg kept", d, 8'h0a);
      rd(2'd2, d); chk("R12 read2", d, 8'h00);
      rd(2'd3, d); chk("R12 read3", d, 8'h00);
      repeat (3) @(negedge clk);
      chk("R7 sticky", {rst_mac_tx, rst_mac_rx, rst_ctl_sub, rst_rng, rst_mac_core},
          exp_dom(6'h0a));

      // R8 R9: transmit pulse
      wr(2'd1, 8'h01);
      chk_dp("R8 R9 tx c1", 1, 1, 0, 0);
      @(negedge clk); chk_dp("R8 R9 tx c2", 1, 0, 0, 0);
      @(negedge clk); chk_dp("R8 tx c3", 0, 0, 0, 0);
      rd(2'd0, d); chk("R7 cfg after cmd", d, 8'h0a);

      // R10: receive pulse, then both together
      wr(2'd1, 8'h02);
      chk_dp("R10 rx c1", 0, 0, 1, 1);
      @(negedge clk); chk_dp("R10 rx c2", 0, 0, 1, 0);
      @(negedge clk); chk_dp("R10 rx c3", 0, 0, 0, 0);
      wr(2'd1, 8'h03);
      chk_dp("R10 both c1", 1, 1, 1, 1);
      @(negedge clk); chk_dp("R10 both c2", 1, 0, 1, 0);
      @(negedge clk); chk_dp("R10 both c3", 0, 0, 0, 0);

      // R11: zero write does nothing
      wr(2'd1, 8'h00);
      chk_dp("R11 zero c1", 0, 0, 0, 0);
      @(negedge clk); chk_dp("R11 zero c2", 0, 0, 0, 0);

      // R11: rewrite during pulse restarts window
      @(negedge clk);
      addr = 2'd1; wdata = 8'h01; wr_en = 1'b1;
      @(negedge clk);            // first write captured
      chk("R11 rearm c1", {rst_tx_dp, tx_abort}, 2'b11);
      @(negedge clk); wr_en = 1'b0; // second write captured
      chk_dp("R11 rearm c2", 1, 1, 0, 0);
      @(negedge clk); chk_dp("R11 rearm c3", 1, 0, 0, 0);
      @(negedge clk); chk_dp("R11 rearm c4", 0, 0, 0, 0);

      // R11: zero write in a pulse does not stop it
      wr(2'd1, 8'h02);
      @(negedge clk);
      addr = 2'd1; wdata = 8'h00; wr_en = 1'b1;
      chk("R11 zero mid", rst_rx_dp, 1'b1);
      @(negedge clk); wr_en = 1'b0;
      chk_dp("R11 zero mid end", 0, 0, 0, 0);

      // R1: mid-run hard reset is immediate
      wr(2'd0, 8'h00);
      chk("R3 all clear", {rst_mac_tx, rst_mac_rx, rst_ctl_sub, rst_rng, rst_mac_core}, 5'h00);
      #2 hard_rst_n = 1'b0;
      #1;
      chk("R1 async", {rst_mac_tx, rst_mac_rx, rst_ctl_sub, rst_rng, rst_mac_core,
                       rst_tx_dp, rst_rx_dp}, 7'h7f);
      rd(2'd0, d); chk("R1 cfg default", d, 8'h20);
      @(negedge clk); hard_rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R2 after rerelease", {rst_tx_dp, rst_mac_core}, 2'b01);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule